// File: doc/BRIEF.md
# Fixed-Window Bank Controller with Cycle Timer Interrupt

This block is a small cartridge mapper controller. It splits the CPU space from $6000 to $FFFF into five 8 KiB windows and gives each window a PRG bank number. In its plain map, four windows are pinned to set banks and only the $C000 window follows a bank register that software writes. An interval timer counts CPU clock cycles once software arms it. When the interval ends it raises an interrupt line, which stays high until software acknowledges it.

A build parameter adds an outer register. This register is loaded from the low address bits of the write, not from the data bus. It selects the CHR 8 KiB bank and the nametable mirroring. It can also swap the whole 8 KiB ROM map for a 16 KiB mirrored map or a 32 KiB map. Writes in $8000-$FFFF are decoded on A14..A13. The reset button clears only the outer register. Power-on clears everything.

Top module: `fixwin_bank_ctrl`

## Requirements
- R1: After power-on (`por` high at a clock edge) the windows read $6000=6, $8000=4, $A000=5, $C000=0, $E000=7. The CHR bank is 0, mirroring is vertical (`mirror_horiz`=0) and `irq` is low. `irq` stays low until a later arm write.
- R2: A write with A15=1 and A14..A13=11 loads the switchable bank from data bits 2..0. Data bits 7..3 have no effect.
- R3: With outer bit 3 clear, the windows are $6000=6, $8000=4, $A000=5, $C000=switchable bank and $E000=7.
- R4: With the outer register built in, a write with A15=1 and A14..A13=10 loads the outer register from A7..A0. The data bus is ignored.
- R5: With outer bits 3 and 4 both set, the 32 KiB bank (2 OR outer>>6) fills $8000-$FFFF. Its 8 KiB banks are bank*4+0..3 in address order. $6000 stays 6.
- R6: With outer bit 3 set and bit 4 clear, the 16 KiB bank (4 OR outer>>5) appears at both $8000 and $C000. $8000/$C000 show bank*2 and $A000/$E000 show bank*2+1.
- R7: The CHR bank equals outer>>1 (7 bits). Outer bit 0 = 1 selects horizontal mirroring and 0 selects vertical.
- R8: A write with A15=1 and A14..A13=01 arms the timer. `irq` rises at exactly the IRQ_CYCLES-th rising clock edge after the arming edge. It then holds high with the counter stopped.
- R9: A write with A15=1 and A14..A13=00 drops `irq` at the next edge, disarms the timer and zeroes its count. A fresh arm then takes a full IRQ_CYCLES again.
- R10: The reset button (`rst`) clears the outer register only. The switchable bank and a pending `irq` survive it.
- R11: Writes with A15=0 change no output.
- R12: In the plain variant (HAS_OUTER=0), writes in the $C000 range have no effect. The map stays the R3 map, the CHR bank stays 0 and mirroring stays vertical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU cycle clock |
| rst | input | 1 | Synchronous reset button, active high |
| por | input | 1 | Synchronous power-on clear, active high |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus |
| cpu_wr | input | 1 | One-cycle write strobe |
| prg_w6 | output | 4 | 8 KiB PRG bank for $6000 |
| prg_w8 | output | 4 | 8 KiB PRG bank for $8000 |
| prg_wa | output | 4 | 8 KiB PRG bank for $A000 |
| prg_wc | output | 4 | 8 KiB PRG bank for $C000 |
| prg_we | output | 4 | 8 KiB PRG bank for $E000 |
| chr_bank | output | 7 | 8 KiB CHR bank |
| mirror_horiz | output | 1 | 1 = horizontal, 0 = vertical mirroring |
| irq | output | 1 | Timer interrupt, active high |

## Verification
The bank map is tried with several outer values. 0x18 and 0xD8 separate the two 32 KiB banks. 0xE9 shows the 16 KiB mirror together with odd CHR and mirror bits. A return to 0x00 proves that the switchable bank was kept while it was hidden. Data bits on the outer write and high data bits on the bank write are set to values that would expose a wrong bus source. The timer is sampled one edge before and exactly at the expected rise, after a partial count has been acknowledged away, which tells an exact count from an off-by-one or a counter that is not cleared. Reset and power-on are pulsed with state already loaded, which separates what each of them clears.

// File: rtl/fixwin_pkg.sv
package fixwin_pkg;

    localparam int BANK_W  = 4;
    localparam int SEL_W   = 3;
    localparam int OUTER_W = 8;
    localparam int CHR_W   = OUTER_W - 1;
    localparam int NUM_ROM_WIN = 4;

    localparam int OB_MIRROR = 0;
    localparam int OB_BIG    = 3;
    localparam int OB_WIDE   = 4;

    typedef logic [BANK_W-1:0]  bank_t;
    typedef logic [SEL_W-1:0]   sel_t;
    typedef logic [OUTER_W-1:0] outer_t;

    typedef enum logic [1:0] {
        RGN_ACK   = 2'b00,
        RGN_ARM   = 2'b01,
        RGN_OUTER = 2'b10,
        RGN_SEL   = 2'b11
    } region_e;

    typedef enum logic [1:0] {
        MAP_8K,
        MAP_16K,
        MAP_32K
    } map_mode_e;

    typedef struct packed {
        logic   ack;
        logic   arm;
        logic   outer_ld;
        logic   sel_ld;
        outer_t outer_val;
        sel_t   sel_val;
    } wr_cmd_t;

    typedef struct packed {
        bank_t w6;
        bank_t w8;
        bank_t wa;
        bank_t wc;
        bank_t we;
    } win_map_t;

    localparam bank_t LOW_WIN_BANK = bank_t'(6);

    function automatic map_mode_e mode_of(input outer_t o);
        if (!o[OB_BIG])
            return MAP_8K;
        else if (o[OB_WIDE])
            return MAP_32K;
        else
            return MAP_16K;
    endfunction

    function automatic bank_t pinned_bank(input int idx);
        case (idx)
            0:       return bank_t'(4);
            1:       return bank_t'(5);
            default: return bank_t'(7);
        endcase
    endfunction

endpackage

// File: rtl/fixwin_decode.sv
module fixwin_decode
    import fixwin_pkg::*;
#(
    parameter bit HAS_OUTER = 1'b1
) (
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_data,
    input  logic        cpu_wr,
    output wr_cmd_t     cmd
);

    logic    hit;
    region_e rgn;
    logic    outer_hit;
    logic    unused_bits;

    assign hit = cpu_wr && cpu_addr[15];
    assign rgn = region_e'(cpu_addr[14:13]);
    assign unused_bits = ^{cpu_addr[12:8], cpu_data[7:SEL_W]};

    generate
        if (HAS_OUTER) begin : g_outer
            assign outer_hit = hit && (rgn == RGN_OUTER);
        end else begin : g_plain
            assign outer_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        cmd           = '0;
        cmd.ack       = hit && (rgn == RGN_ACK);
        cmd.arm       = hit && (rgn == RGN_ARM);
        cmd.sel_ld    = hit && (rgn == RGN_SEL);
        cmd.outer_ld  = outer_hit;
        cmd.outer_val = cpu_addr[OUTER_W-1:0];
        cmd.sel_val   = cpu_data[SEL_W-1:0];
    end

endmodule

// File: rtl/fixwin_regs.sv
module fixwin_regs
    import fixwin_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    por,
    input  wr_cmd_t cmd,
    output outer_t  outer_q,
    output sel_t    sel_q
);

    always_ff @(posedge clk) begin
        if (por || rst)
            outer_q <= '0;
        else if (cmd.outer_ld)
            outer_q <= cmd.outer_val;
    end

    always_ff @(posedge clk) begin
        if (por)
            sel_q <= '0;
        else if (cmd.sel_ld)
            sel_q <= cmd.sel_val;
    end

endmodule

// File: rtl/fixwin_irq_timer.sv
module fixwin_irq_timer
    import fixwin_pkg::*;
#(
    parameter int IRQ_CYCLES = 4096
) (
    input  logic    clk,
    input  logic    por,
    input  wr_cmd_t cmd,
    output logic    irq
);

    localparam int CNT_W = (IRQ_CYCLES > 2) ? $clog2(IRQ_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(IRQ_CYCLES - 1);

    logic             armed_q;
    logic [CNT_W-1:0] cnt_q;
    logic             irq_q;

    always_ff @(posedge clk) begin
        if (por || cmd.ack) begin
            armed_q <= 1'b0;
            cnt_q   <= '0;
            irq_q   <= 1'b0;
        end else begin
            if (cmd.arm)
                armed_q <= 1'b1;
            if (armed_q && !irq_q) begin
                if (cnt_q == LAST)
                    irq_q <= 1'b1;
                else
                    cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign irq = irq_q;

endmodule

// File: rtl/fixwin_bank_map.sv
module fixwin_bank_map
    import fixwin_pkg::*;
(
    input  outer_t   outer,
    input  sel_t     sel,
    output win_map_t map
);

    map_mode_e                          mode;
    logic [NUM_ROM_WIN-1:0][BANK_W-1:0] rom;
    logic                               unused_bits;

    assign mode        = mode_of(outer);
    assign unused_bits = ^{outer[7], outer[2:0]};

    generate
        for (genvar i = 0; i < NUM_ROM_WIN; i++) begin : g_win
            localparam logic [1:0] IDX = 2'(i);
            bank_t b;
            always_comb begin
                case (mode)
                    MAP_32K: b = {1'b1, outer[6], IDX};
                    MAP_16K: b = {1'b1, outer[6], outer[5], IDX[0]};
                    default: begin
                        if (i == 2)
                            b = bank_t'(sel);
                        else
                            b = pinned_bank(i);
                    end
                endcase
            end
            assign rom[i] = b;
        end
    endgenerate

    always_comb begin
        map.w6 = LOW_WIN_BANK;
        map.w8 = rom[0];
        map.wa = rom[1];
        map.wc = rom[2];
        map.we = rom[3];
    end

endmodule

// File: rtl/fixwin_bank_ctrl.sv
module fixwin_bank_ctrl
    import fixwin_pkg::*;
#(
    parameter bit HAS_OUTER  = 1'b1,
    parameter int IRQ_CYCLES = 4096
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        por,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_data,
    input  logic        cpu_wr,
    output logic [3:0]  prg_w6,
    output logic [3:0]  prg_w8,
    output logic [3:0]  prg_wa,
    output logic [3:0]  prg_wc,
    output logic [3:0]  prg_we,
    output logic [6:0]  chr_bank,
    output logic        mirror_horiz,
    output logic        irq
);

    wr_cmd_t  cmd;
    outer_t   outer_q;
    sel_t     sel_q;
    win_map_t map;

    fixwin_decode #(.HAS_OUTER(HAS_OUTER)) u_dec (
        .cpu_addr (cpu_addr),
        .cpu_data (cpu_data),
        .cpu_wr   (cpu_wr),
        .cmd      (cmd)
    );

    fixwin_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .por     (por),
        .cmd     (cmd),
        .outer_q (outer_q),
        .sel_q   (sel_q)
    );

    fixwin_irq_timer #(.IRQ_CYCLES(IRQ_CYCLES)) u_tmr (
        .clk (clk),
        .por (por),
        .cmd (cmd),
        .irq (irq)
    );

    fixwin_bank_map u_map (
        .outer (outer_q),
        .sel   (sel_q),
        .map   (map)
    );

    assign prg_w6       = map.w6;
    assign prg_w8       = map.w8;
    assign prg_wa       = map.wa;
    assign prg_wc       = map.wc;
    assign prg_we       = map.we;
    assign chr_bank     = outer_q[OUTER_W-1:1];
    assign mirror_horiz = outer_q[OB_MIRROR];

endmodule

// File: rtl/fixwin_checks.sv
module fixwin_checks (
    input logic        clk,
    input logic        rst,
    input logic        por,
    input logic [15:0] cpu_addr,
    input logic        cpu_wr,
    input logic [7:0]  outer,
    input logic [3:0]  prg_w6,
    input logic [3:0]  prg_w8,
    input logic [3:0]  prg_wa,
    input logic [3:0]  prg_wc,
    input logic [3:0]  prg_we,
    input logic [6:0]  chr_bank,
    input logic        mirror_horiz,
    input logic        irq
);

    logic ack_wr;
    assign ack_wr = cpu_wr && (cpu_addr[15:13] == 3'b100);

    AST_POR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        por |=> (!irq && outer == 8'h00));  // R1

    AST_FIXED_MAP: assert property (@(posedge clk) disable iff (rst || por)
        !outer[3] |-> (prg_w6 == 4'd6 && prg_w8 == 4'd4 && prg_wa == 4'd5 && prg_we == 4'd7));  // R3

    AST_WIDE_RUN: assert property (@(posedge clk) disable iff (rst || por)
        (outer[3] && outer[4]) |-> (prg_wa == prg_w8 + 4'd1 && prg_wc == prg_w8 + 4'd2
                                    && prg_we == prg_w8 + 4'd3 && prg_w6 == 4'd6));  // R5

    AST_HALF_MIRROR: assert property (@(posedge clk) disable iff (rst || por)
        (outer[3] && !outer[4]) |-> (prg_w8 == prg_wc && prg_wa == prg_we && prg_wa == prg_w8 + 4'd1));  // R6

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst || por)
        (irq && !ack_wr) |=> irq);  // R8

    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (rst || por)
        ack_wr |=> !irq);  // R9

    AST_LOW_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst || por)
        (cpu_wr && !cpu_addr[15]) |=> ($stable(prg_w8) && $stable(prg_wa) && $stable(prg_wc)
                                       && $stable(prg_we) && $stable(chr_bank) && $stable(mirror_horiz)));  // R11

endmodule

bind fixwin_bank_ctrl fixwin_checks u_chk (
    .clk          (clk),
    .rst          (rst),
    .por          (por),
    .cpu_addr     (cpu_addr),
    .cpu_wr       (cpu_wr),
    .outer        (outer_q),
    .prg_w6       (prg_w6),
    .prg_w8       (prg_w8),
    .prg_wa       (prg_wa),
    .prg_wc       (prg_wc),
    .prg_we       (prg_we),
    .chr_bank     (chr_bank),
    .mirror_horiz (mirror_horiz),
    .irq          (irq)
);

// File: tb/sim_fixwin_bank_ctrl.sv
`timescale 1ns/1ps
module sim_fixwin_bank_ctrl;

    localparam int N = 4096;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        por = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_data = '0;
    logic        cpu_wr = 1'b0;

    logic [3:0] a_w6, a_w8, a_wa, a_wc, a_we;
    logic [6:0] a_chr;
    logic       a_mir, a_irq;
    logic [3:0] b_w6, b_w8, b_wa, b_wc, b_we;
    logic [6:0] b_chr;
    logic       b_mir, b_irq;

    always #4 clk = ~clk;

    fixwin_bank_ctrl #(.HAS_OUTER(1'b1), .IRQ_CYCLES(N)) u0 (
        .clk(clk), .rst(rst), .por(por), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
        .prg_w6(a_w6), .prg_w8(a_w8), .prg_wa(a_wa), .prg_wc(a_wc), .prg_we(a_we),
        .chr_bank(a_chr), .mirror_horiz(a_mir), .irq(a_irq));

    fixwin_bank_ctrl #(.HAS_OUTER(1'b0), .IRQ_CYCLES(N)) u1 (
        .clk(clk), .rst(rst), .por(por), .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_wr(cpu_wr),
        .prg_w6(b_w6), .prg_w8(b_w8), .prg_wa(b_wa), .prg_wc(b_wc), .prg_we(b_we),
        .chr_bank(b_chr), .mirror_horiz(b_mir), .irq(b_irq));

    typedef struct {
        string       req;
        bit          plain;
        logic [28:0] val;
    } item_t;

    item_t q[$];
    int compared = 0;
    int mismatched = 0;
    bit done = 0;

    logic [7:0] m_outer = '0;
    logic [2:0] m_sel = '0;
    logic       m_irq = 1'b0;

    function automatic logic [3:0] model_bank(input logic [7:0] o, input logic [2:0] s, input int w);
        int b;
        if (w == 0) return 4'd6;
        if (o[3] && o[4]) begin
            b = (2 | (o >> 6)) * 4 + (w - 1);
        end else if (o[3]) begin
            b = (4 | (o >> 5)) * 2 + ((w - 1) % 2);
        end else begin
            case (w)
                1: b = 4;
                2: b = 5;
                3: b = s;
                default: b = 7;
            endcase
        end
        return 4'(b);
    endfunction

    task automatic push(input string req, input bit plain);
        item_t it;
        logic [7:0] o;
        o = plain ? 8'h00 : m_outer;
        it.req = req;
        it.plain = plain;
        it.val = {model_bank(o, m_sel, 0), model_bank(o, m_sel, 1), model_bank(o, m_sel, 2),
                  model_bank(o, m_sel, 3), model_bank(o, m_sel, 4), o[7:1], o[0], m_irq};
        q.push_back(it);
    endtask

    task automatic chk(input string req);
        #1 push(req, 1'b0);
        @(negedge clk);
    endtask

    task automatic chk_plain(input string req);
        #1 push(req, 1'b1);
        @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a;
        cpu_data = d;
        cpu_wr   = 1'b1;
        @(negedge clk);
        cpu_wr   = 1'b0;
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t e;
            logic [28:0] act;
            e = q.pop_front();
            act = e.plain ? {b_w6, b_w8, b_wa, b_wc, b_we, b_chr, b_mir, b_irq}
                          : {a_w6, a_w8, a_wa, a_wc, a_we, a_chr, a_mir, a_irq};
            compared++;
            if (act !== e.val) begin
                mismatched++;
                $display("FAIL %s: actual %h expected %h (w6 w8 wa wc we chr mir irq)", e.req, act, e.val);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        por = 1'b0;
        chk("R1 power-on state");

        wr(16'hE000, 8'hFD); m_sel = 3'd5;
        chk("R2 bank write uses data bits 2..0 / R3 8K map");

        wr(16'h6018, 8'hFF);
        wr(16'h7FFF, 8'hFF);
        chk("R11 writes below 8000 ignored");

        wr(16'hC018, 8'h00); m_outer = 8'h18;
        chk("R4 outer from address / R5 32K bank 2 / R7 chr");

        wr(16'hC0D8, 8'hFF); m_outer = 8'hD8;
        chk("R5 32K bank 3 / R7 chr");

        wr(16'hC0E9, 8'h55); m_outer = 8'hE9;
        chk("R6 16K mirror / R7 chr and horizontal mirroring");

        wr(16'hC000, 8'hFF); m_outer = 8'h00;
        chk("R3 back to 8K keeps switchable bank");

        wr(16'hC0E9, 8'h00);
        chk_plain("R12 plain variant ignores outer write");
        m_outer = 8'hE9;
        chk("R4 outer variant took the same write");
        wr(16'hC000, 8'h00); m_outer = 8'h00;

        wr(16'hA000, 8'h00);
        repeat (2000) @(negedge clk);
        chk("R8 irq low mid-count");
        wr(16'h8000, 8'h00);
        wr(16'hA000, 8'h00);
        repeat (N - 2) @(negedge clk);
        m_irq = 1'b0;
        chk("R9 R8 irq low one edge before interval after cleared count");
        m_irq = 1'b1;
        chk("R8 irq rises at exact interval");
        repeat (50) @(negedge clk);
        chk("R8 irq held");

        wr(16'hC0E9, 8'h00); m_outer = 8'hE9;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        m_outer = 8'h00;
        chk("R10 reset clears outer only");

        wr(16'h8000, 8'h00); m_irq = 1'b0;
        chk("R9 acknowledge drops irq");
        repeat (N + 900) @(negedge clk);
        chk("R9 timer stays disarmed");

        wr(16'hE000, 8'h03); m_sel = 3'd3;
        wr(16'hC0E9, 8'h00); m_outer = 8'hE9;
        wr(16'hA000, 8'h00);
        @(negedge clk); por = 1'b1;
        @(negedge clk); por = 1'b0;
        m_outer = 8'h00; m_sel = 3'd0; m_irq = 1'b0;
        chk("R1 power-on clears all state");
        repeat (N + 100) @(negedge clk);
        chk("R1 no irq after power-on without arm");

        repeat (2) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule